// File: doc/BRIEF.md
# Program Counter and Next-Address Selector

This block holds the program counter of a single-cycle processor core and chooses the address of the next instruction. Every clock it forms four candidate addresses from the current PC and the operands supplied by decode. The first is the sequential address. The second is a PC-relative branch target built on a dedicated adder, separate from the execution ALU. The third is a region-local jump target, which keeps the top PC bits and splices in a word-aligned 26-bit field. The fourth is a target taken from a register.

A 3-bit select code from the control logic picks one of these candidates, or one of three fixed trap addresses. The chosen value is loaded at the clock edge. One instruction retires per clock.

The current PC drives instruction-memory addressing. The sequential address is also brought out so that link instructions can write it into the register file. Reset is synchronous and active low. While it is asserted it overrides the select code.

Top module: `next_pc_unit`

## Requirements
- R1: A clock edge with `rst_n` low loads the PC with 0x80000000, whatever the select code, and `pc_o` shows that value after the edge.
- R2: Select code 0 loads PC+4, modulo 2^32 (0xFFFFFFFC wraps to 0x00000000).
- R3: Select code 1 loads PC + 4 + (sign-extended `imm16_i` shifted left by two), modulo 2^32. Bit 15 of `imm16_i` is the sign bit.
- R4: Select code 2 loads {PC[31:28], `imm26_i`, 2'b00}. The upper four bits come from the current PC, not from PC+4.
- R5: Select code 3 loads `jreg_i` unchanged, including its two low bits.
- R6: Select code 4 (illegal opcode) loads 0x80000040.
- R7: Select code 5 (interrupt) loads 0x80000080.
- R8: Select code 6 loads the reset address 0x80000000 without asserting `rst_n`.
- R9: Select code 7 is unused and behaves exactly like code 0.
- R10: `pc_plus4_o` equals `pc_o` + 4 modulo 2^32 in every cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC loads on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_sel_i | input | 3 | Next-address select code (0..7, see R2-R9) |
| imm16_i | input | 16 | Branch offset in words, two's complement |
| imm26_i | input | 26 | Jump word index within the current 256 MiB region |
| jreg_i | input | 32 | Register value for indirect jumps |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | Current PC plus four, for linking |

## Verification
Each select code has an assertion that checks its effect on every cycle: the PC after an edge is related to the PC, select code and operands of the cycle before. The sequential output is checked against the PC continuously, and a reset edge is followed by a check of the reset address.

Some behaviour only the bench scenarios can show:
- carry wrap-around at the top of the address space;
- negative branch offsets that cross zero;
- jumps that keep a high region nibble;
- reset winning over each of the eight select codes.

The bench sweeps all eight codes from seven starting PCs with boundary immediates and compares every result with arithmetic it computes itself.

// File: rtl/pc_sel_pkg.sv
// Package: pc_sel_pkg
// Shared select-code encoding and the fixed trap addresses for the
// next-address logic. Assumes a 3-bit select code from control.
package pc_sel_pkg;

    // Select code for the next program counter
    typedef enum logic [2:0] {
        PCS_SEQ     = 3'd0,
        PCS_BRANCH  = 3'd1,
        PCS_JUMP    = 3'd2,
        PCS_REG     = 3'd3,
        PCS_ILLEGAL = 3'd4,
        PCS_IRQ     = 3'd5,
        PCS_RESET   = 3'd6,
        PCS_SPARE   = 3'd7
    } pc_sel_e;

    localparam logic [31:0] VEC_RESET   = 32'h8000_0000;
    localparam logic [31:0] VEC_ILLEGAL = 32'h8000_0040;
    localparam logic [31:0] VEC_IRQ     = 32'h8000_0080;

endpackage

// File: rtl/pc_target_calc.sv
// Module: pc_target_calc
// Forms the sequential, branch and region-jump candidate addresses from the
// current PC. Purely combinational. Assumes byte addressing with word-sized
// instructions, so offsets are scaled by four through wiring alone.
module pc_target_calc #(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 16,
    parameter int JIMM_W = 26
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [IMM_W-1:0]  imm16_i,
    input  logic [JIMM_W-1:0] imm26_i,
    output logic [XLEN-1:0]   seq_o,
    output logic [XLEN-1:0]   branch_o,
    output logic [XLEN-1:0]   jump_o
);
    localparam int EXT_W = XLEN - IMM_W - 2;
    localparam int HI_W  = XLEN - JIMM_W - 2;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] offset_bytes;

    // Sequential address from the incrementer
    always_comb seq_o = pc_i + STEP;

    // Sign-extend the word offset and scale it by four
    always_comb offset_bytes = {{EXT_W{imm16_i[IMM_W-1]}}, imm16_i, 2'b00};

    // Dedicated branch adder, independent of the execution ALU
    always_comb branch_o = seq_o + offset_bytes;

    // Region jump: keep the top PC bits when any remain above the field
    generate
        if (HI_W > 0) begin : g_region
            always_comb jump_o = {pc_i[XLEN-1 -: HI_W], imm26_i, 2'b00};
        end else begin : g_flat
            always_comb jump_o = XLEN'({imm26_i, 2'b00});
        end
    endgenerate

endmodule

// File: rtl/pc_next_mux.sv
// Module: pc_next_mux
// Chooses the next PC from the candidate addresses and the fixed trap
// addresses. Assumes the select code is valid every cycle; the spare code
// falls back to the sequential address.
module pc_next_mux
    import pc_sel_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RST_ADDR = VEC_RESET,
    parameter logic [XLEN-1:0] ILL_ADDR = VEC_ILLEGAL,
    parameter logic [XLEN-1:0] IRQ_ADDR = VEC_IRQ
) (
    input  logic [2:0]      sel_i,
    input  logic [XLEN-1:0] seq_i,
    input  logic [XLEN-1:0] branch_i,
    input  logic [XLEN-1:0] jump_i,
    input  logic [XLEN-1:0] reg_i,
    output logic [XLEN-1:0] next_o
);
    // Seven-way selection driven by the control code
    always_comb begin
        unique case (pc_sel_e'(sel_i))
            PCS_BRANCH:  next_o = branch_i;
            PCS_JUMP:    next_o = jump_i;
            PCS_REG:     next_o = reg_i;
            PCS_ILLEGAL: next_o = ILL_ADDR;
            PCS_IRQ:     next_o = IRQ_ADDR;
            PCS_RESET:   next_o = RST_ADDR;
            default:     next_o = seq_i;
        endcase
    end

endmodule

// File: rtl/pc_register.sv
// Module: pc_register
// Holds the program counter. Synchronous active-low reset loads the reset
// address and takes precedence over the selected next value.
module pc_register #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RST_ADDR = 32'h8000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] next_i,
    output logic [XLEN-1:0] pc_o
);
    logic [XLEN-1:0] pc_q;
    logic            rst_seen_q;

    // PC state: reset wins, otherwise load the chosen next address
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RST_ADDR;
        else        pc_q <= next_i;
    end

    // Remember that the previous edge was a reset edge
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
        if (rst_seen_q) begin
            // R1
            reset_addr_chk: assert (pc_q == RST_ADDR)
                else $error("PC not at reset address after reset");
        end
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/next_pc_unit.sv
// Module: next_pc_unit
// Top of the program counter and next-address logic for a single-cycle
// core. Assumes decode supplies the select code and operands during the same
// cycle in which they are to take effect.
module next_pc_unit
    import pc_sel_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 16,
    parameter int JIMM_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        pc_sel_i,
    input  logic [IMM_W-1:0]  imm16_i,
    input  logic [JIMM_W-1:0] imm26_i,
    input  logic [XLEN-1:0]   jreg_i,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   pc_plus4_o
);
    localparam int EXT_W = XLEN - IMM_W - 2;
    localparam int HI_W  = XLEN - JIMM_W - 2;
    localparam logic [XLEN-1:0] RST_A = XLEN'(VEC_RESET);
    localparam logic [XLEN-1:0] ILL_A = XLEN'(VEC_ILLEGAL);
    localparam logic [XLEN-1:0] IRQ_A = XLEN'(VEC_IRQ);

    logic [XLEN-1:0] seq_w, branch_w, jump_w, next_w;

    pc_target_calc #(.XLEN(XLEN), .IMM_W(IMM_W), .JIMM_W(JIMM_W)) u_calc (
        .pc_i     (pc_o),
        .imm16_i  (imm16_i),
        .imm26_i  (imm26_i),
        .seq_o    (seq_w),
        .branch_o (branch_w),
        .jump_o   (jump_w)
    );

    pc_next_mux #(
        .XLEN(XLEN), .RST_ADDR(RST_A), .ILL_ADDR(ILL_A), .IRQ_ADDR(IRQ_A)
    ) u_mux (
        .sel_i    (pc_sel_i),
        .seq_i    (seq_w),
        .branch_i (branch_w),
        .jump_i   (jump_w),
        .reg_i    (jreg_i),
        .next_o   (next_w)
    );

    pc_register #(.XLEN(XLEN), .RST_ADDR(RST_A)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .next_i (next_w),
        .pc_o   (pc_o)
    );

    // Link value shares the sequential incrementer
    assign pc_plus4_o = seq_w;

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_i == PCS_SEQ |=> pc_o == $past(pc_o) + XLEN'(4));
    // R3
    branch_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_i == PCS_BRANCH |=> pc_o == $past(pc_o) + XLEN'(4)
            + {{EXT_W{$past(imm16_i[IMM_W-1])}}, $past(imm16_i), 2'b00});
    // R4
    jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_i == PCS_JUMP |=> pc_o[XLEN-1 -: HI_W] == $past(pc_o[XLEN-1 -: HI_W])
            && pc_o[JIMM_W+1:0] == {$past(imm26_i), 2'b00});
    // R5
    reg_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_i == PCS_REG |=> pc_o == $past(jreg_i));
    // R6
    ill_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_i == PCS_ILLEGAL |=> pc_o == ILL_A);
    // R7
    irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_i == PCS_IRQ |=> pc_o == IRQ_A);
    // R8
    soft_rst_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_i == PCS_RESET |=> pc_o == RST_A);
    // R9
    spare_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_i == PCS_SPARE |=> pc_o == $past(pc_o) + XLEN'(4));
    // R10
    link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_plus4_o - pc_o == XLEN'(4));

endmodule

// File: tb/next_pc_unit_tb.sv
module next_pc_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pc_sel_i = 3'd0;
    logic [15:0] imm16_i = '0;
    logic [25:0] imm26_i = '0;
    logic [31:0] jreg_i = '0;
    logic [31:0] pc_o, pc_plus4_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] model_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    next_pc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pc_sel_i(pc_sel_i), .imm16_i(imm16_i),
        .imm26_i(imm26_i), .jreg_i(jreg_i), .pc_o(pc_o), .pc_plus4_o(pc_plus4_o)
    );

    function automatic logic [31:0] expect_next(input logic [31:0] pc,
        input logic [2:0] s, input logic [15:0] i16, input logic [25:0] i26,
        input logic [31:0] jr);
        logic [31:0] off;
        off = {{14{i16[15]}}, i16, 2'b00};
        case (s)
            3'd1: return pc + 32'd4 + off;
            3'd2: return {pc[31:28], i26, 2'b00};
            3'd3: return jr;
            3'd4: return 32'h8000_0040;
            3'd5: return 32'h8000_0080;
            3'd6: return 32'h8000_0000;
            default: return pc + 32'd4;   // codes 0 and 7
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check32(input string tag, input logic [31:0] act,
                           input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Drive one select code for one edge and check the result
    task automatic step(input logic [2:0] s, input logic [15:0] i16,
                        input logic [25:0] i26, input logic [31:0] jr);
        logic [31:0] exp;
        pc_sel_i = s; imm16_i = i16; imm26_i = i26; jreg_i = jr;
        exp = expect_next(model_pc, s, i16, i26, jr);
        @(posedge clk);
        @(negedge clk);
        check32(tag_of(s), pc_o, exp);
        check32("R10", pc_plus4_o, exp + 32'd4);
        model_pc = exp;
    endtask

    // Reset edge with an arbitrary select code: reset must win
    task automatic reset_with(input logic [2:0] s);
        rst_n = 1'b0; pc_sel_i = s; imm16_i = 16'h8001; imm26_i = 26'h155_5555;
        jreg_i = 32'hDEAD_BEE0;
        @(posedge clk);
        @(negedge clk);
        check32("R1", pc_o, 32'h8000_0000);
        rst_n = 1'b1;
        model_pc = 32'h8000_0000;
    endtask

    initial begin
        logic [31:0] bases [7];
        logic [15:0] offs  [5];
        logic [25:0] jidx  [3];
        bases = '{32'h0000_0000, 32'h0000_1000, 32'h7FFF_FFFC, 32'h8000_0000,
                  32'hFFFF_FFFC, 32'h1234_5678, 32'hF000_0004};
        offs  = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
        jidx  = '{26'h000_0000, 26'h3FF_FFFF, 26'h2AA_AAAA};

        repeat (3) @(negedge clk);
        check32("R1", pc_o, 32'h8000_0000);   // reset state
        check32("R10", pc_plus4_o, 32'h8000_0004);
        rst_n = 1'b1;
        model_pc = 32'h8000_0000;

        for (int b = 0; b < 7; b++) begin
            for (int s = 0; s < 8; s++) begin
                for (int k = 0; k < 5; k++) begin
                    step(3'd3, offs[k], jidx[k % 3], bases[b]);   // R5 preset
                    step(3'(s), offs[k], jidx[k % 3], ~bases[b] ^ 32'(k));
                end
            end
        end

        // Consecutive sequential steps wrapping through zero (R2)
        step(3'd3, 16'h0, 26'h0, 32'hFFFF_FFF8);
        step(3'd0, 16'h0, 26'h0, 32'h0);
        step(3'd0, 16'h0, 26'h0, 32'h0);
        step(3'd0, 16'h0, 26'h0, 32'h0);

        for (int s = 0; s < 8; s++) reset_with(3'(s));   // R1 priority
        step(3'd0, 16'h0, 26'h0, 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule